// File: doc/BRIEF.md
# LED Matrix Bit-Plane Scan Controller

This block refreshes a row-multiplexed LED matrix (16 rows by 16 columns by default) and produces grey levels from weighted bit-planes. For each row it shows several planes one after another. Each plane stays on the columns for its own dwell time, counted in ticks of a prescaled timebase. The column pattern comes from a frame buffer outside the block. The buffer has a synchronous read port with one cycle of latency, and each entry holds two column bytes for one plane of one row.

Rows are selected by an external one-hot shift register that the block drives through a serial data pin and a clock pin. When the last plane of a row has been shown, the block blanks the columns and waits a short settle time. It then clocks the shift register, waits a longer settle time, and fetches the next row's first plane. When it enters row 0 it injects a fresh token; every other row step is a plain clock pulse. Build-time options invert the shift-register data levels, interlace the physical rows onto buffer rows, bit-reverse and swap the two column bytes, or spread the two bytes onto alternating columns. A disable input silences every output and restarts the scan from its initial state.

The sequencer has seven states. OFF is entered whenever `dis` is high and goes to DWELL once `dis` is low. In DWELL the timebase runs. When the dwell expires, DWELL goes to FETCH, or to BLANK if the plane just shown was the last one. BLANK waits SETTLE_PRE cycles and goes to SHIFT. SHIFT lasts four cycles and goes to SETTLE, which waits SETTLE_POST cycles and goes to FETCH. FETCH issues the buffer read and goes to LOAD. LOAD latches the remapped data and goes back to DWELL.

Top module: `led_scan_ctrl`

## Requirements
- R1: Reset or the end of a disable starts the scan in DWELL, with all columns off, the shift-register data line at its idle level, plane index NUM_PLANES-1, row index NUM_ROWS-1 and a dwell compare value of START_DWELL (20). The first dwell therefore lasts (START_DWELL+1)*PRESCALE cycles, and a row change to row 0 follows it.
- R2: A dwell showing plane p lasts (D(p)+1)*PRESCALE clock cycles, where D(0)=3, D(1)=4 and D(p)=22 for every later plane. The columns stay constant throughout the dwell.
- R3: Planes are shown in the order 0,1,..,NUM_PLANES-1 for each row. The row index advances only after the last plane, and it wraps from NUM_ROWS-1 to 0.
- R4: On a row change the columns go to zero in the cycle after the dwell expires. The single shift clock pulse is high exactly SETTLE_POST+3 cycles before the next read, and the columns are zero while it is high.
- R5: Each row change gives exactly one `row_clk` pulse, one cycle wide, and plane steps inside a row give none. When the new row is 0, `row_dat` is at its active level from the cycle before the pulse until the cycle after it. For any other row it stays idle.
- R6: The idle level of `row_dat` is 0, or 1 when INVERT_ROWS=1. The active level is the opposite.
- R7: Each plane step makes exactly one read with `fb_rd_en` high for one cycle. The address is plane*NUM_ROWS + buffer row, with the plane in the upper bits. The columns keep their old value in the cycle after the read and take the new value one cycle later.
- R8: With no column option, `col_out[7:0]` equals `fb_rd_data[7:0]` (byte 0) and `col_out[15:8]` equals `fb_rd_data[15:8]` (byte 1).
- R9: With INTERLACE_ROWS=1, physical row r reads buffer row r>>1 when r is even and (r>>1)+NUM_ROWS/2 when r is odd.
- R10: With REVERSE_COLS=1, `col_out[i]` = byte1[7-i] and `col_out[8+i]` = byte0[7-i] for i=0..7. This option takes precedence over column interlacing.
- R11: With INTERLACE_COLS=1, for i=0..3, `col_out[2i]`=byte0[i], `col_out[2i+1]`=byte1[i], `col_out[8+2i]`=byte0[4+i] and `col_out[9+2i]`=byte1[4+i].
- R12: While `dis` is high, from the first clock edge that samples it, `col_out`, `row_clk`, `row_dat` and `fb_rd_en` are all 0 and the timebase is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dis | input | 1 | Disable: outputs low, timebase stopped, scan restarts afterwards |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_rd_addr | output | clog2(NUM_PLANES)+clog2(NUM_ROWS) | Read address {plane, buffer row} |
| fb_rd_data | input | NUM_COLS | Read data one cycle after the strobe; byte 0 in the low half |
| col_out | output | NUM_COLS | Column drive, bit i = column i |
| row_clk | output | 1 | Row shift-register clock |
| row_dat | output | 1 | Row shift-register serial data |

## Verification
The expiry of the last plane's dwell does three things at the same clock edge: it wraps the plane index, advances the row, and starts column blanking. A plane step and a row change therefore begin together. The bench runs two full frames, so every row, including the 15-to-0 wrap that injects the token, meets this edge. At each read it judges the interval since the previous read, the read address, the count and position of shift clock pulses, the data-line level during the pulse, and the zero columns under it. A disable raised in the middle of a frame is also checked: it overrides whatever step is under way, and the restart afterwards must repeat the reset timing one cycle later.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_DWELL  = 3'd1,
        ST_BLANK  = 3'd2,
        ST_SHIFT  = 3'd3,
        ST_SETTLE = 3'd4,
        ST_FETCH  = 3'd5,
        ST_LOAD   = 3'd6
    } scan_state_e;

    // data set up, clock high, clock low, data released
    localparam int SHIFT_STEPS = 4;

endpackage

// File: rtl/led_scan_timebase.sv
module led_scan_timebase #(
    parameter int PRESCALE = 256,
    parameter int CMP_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CMP_W-1:0] cmp,
    output logic             expire
);
    localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    logic [PS_W-1:0]  pre_q;
    logic [CMP_W-1:0] tick_q;
    logic             tick;

    assign tick   = run && (pre_q == PS_W'(PRESCALE - 1));
    assign expire = tick && (tick_q == cmp);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tick_q <= expire ? '0 : tick_q + CMP_W'(1);
        end else begin
            pre_q  <= pre_q + PS_W'(1);
        end
    end
endmodule

// File: rtl/led_scan_rowmap.sv
module led_scan_rowmap #(
    parameter int NUM_ROWS  = 16,
    parameter int ROW_W     = 4,
    parameter bit INTERLACE = 1'b0
) (
    input  logic [ROW_W-1:0] phys_row,
    output logic [ROW_W-1:0] buf_row
);
    localparam int HALF_ROWS = NUM_ROWS / 2;

    generate
        if (INTERLACE) begin : g_interlace
            assign buf_row = phys_row[0] ? ((phys_row >> 1) + ROW_W'(HALF_ROWS))
                                         : (phys_row >> 1);
        end else begin : g_linear
            assign buf_row = phys_row;
        end
    endgenerate
endmodule

// File: rtl/led_scan_colmap.sv
module led_scan_colmap #(
    parameter int GW         = 8,
    parameter bit REVERSE    = 1'b0,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic [GW-1:0]   lo_byte,
    input  logic [GW-1:0]   hi_byte,
    output logic [2*GW-1:0] cols
);
    localparam int HALF = GW / 2;

    generate
        if (REVERSE) begin : g_reverse
            for (genvar i = 0; i < GW; i++) begin : g_bit
                assign cols[i]      = hi_byte[GW-1-i];
                assign cols[GW + i] = lo_byte[GW-1-i];
            end
        end else if (INTERLEAVE) begin : g_interleave
            for (genvar i = 0; i < HALF; i++) begin : g_bit
                assign cols[2*i]          = lo_byte[i];
                assign cols[2*i + 1]      = hi_byte[i];
                assign cols[GW + 2*i]     = lo_byte[HALF + i];
                assign cols[GW + 2*i + 1] = hi_byte[HALF + i];
            end
        end else begin : g_flat
            assign cols = {hi_byte, lo_byte};
        end
    endgenerate
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl #(
    parameter int NUM_PLANES     = 3,
    parameter int NUM_ROWS       = 16,
    parameter int NUM_COLS       = 16,
    parameter int PRESCALE       = 256,
    parameter int CMP_W          = 8,
    parameter int DWELL_P0       = 3,
    parameter int DWELL_P1       = 4,
    parameter int DWELL_PN       = 22,
    parameter int START_DWELL    = 20,
    parameter int SETTLE_PRE     = 10,
    parameter int SETTLE_POST    = 20,
    parameter bit INVERT_ROWS    = 1'b0,
    parameter bit INTERLACE_ROWS = 1'b0,
    parameter bit REVERSE_COLS   = 1'b0,
    parameter bit INTERLACE_COLS = 1'b0
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           dis,
    output logic                                           fb_rd_en,
    output logic [$clog2(NUM_PLANES)+$clog2(NUM_ROWS)-1:0] fb_rd_addr,
    input  logic [NUM_COLS-1:0]                            fb_rd_data,
    output logic [NUM_COLS-1:0]                            col_out,
    output logic                                           row_clk,
    output logic                                           row_dat
);
    import led_scan_pkg::*;

    localparam int PLANE_W  = $clog2(NUM_PLANES);
    localparam int ROW_W    = $clog2(NUM_ROWS);
    localparam int GW       = NUM_COLS / 2;
    localparam int MAX_WAIT = (SETTLE_PRE > SETTLE_POST)
                              ? ((SETTLE_PRE > SHIFT_STEPS) ? SETTLE_PRE : SHIFT_STEPS)
                              : ((SETTLE_POST > SHIFT_STEPS) ? SETTLE_POST : SHIFT_STEPS);
    localparam int DLY_W    = $clog2(MAX_WAIT + 1);
    localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(NUM_PLANES - 1);
    localparam logic [ROW_W-1:0]   LAST_ROW   = ROW_W'(NUM_ROWS - 1);

    scan_state_e        state_q, state_nx;
    logic [PLANE_W-1:0] plane_q;
    logic [ROW_W-1:0]   row_q;
    logic [ROW_W-1:0]   buf_row;
    logic [DLY_W-1:0]   dly_q;
    logic [CMP_W-1:0]   cmp_q;
    logic [NUM_COLS-1:0] col_q;
    logic [NUM_COLS-1:0] mapped;
    logic               expire;
    logic               plane_last;

    function automatic logic [CMP_W-1:0] dwell_of(input logic [PLANE_W-1:0] p);
        if (p == PLANE_W'(0))      return CMP_W'(DWELL_P0);
        else if (p == PLANE_W'(1)) return CMP_W'(DWELL_P1);
        else                       return CMP_W'(DWELL_PN);
    endfunction

    assign plane_last = (plane_q == LAST_PLANE);

    led_scan_timebase #(
        .PRESCALE (PRESCALE),
        .CMP_W    (CMP_W)
    ) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_DWELL),
        .cmp    (cmp_q),
        .expire (expire)
    );

    led_scan_rowmap #(
        .NUM_ROWS  (NUM_ROWS),
        .ROW_W     (ROW_W),
        .INTERLACE (INTERLACE_ROWS)
    ) u_rowmap (
        .phys_row (row_q),
        .buf_row  (buf_row)
    );

    led_scan_colmap #(
        .GW         (GW),
        .REVERSE    (REVERSE_COLS),
        .INTERLEAVE (INTERLACE_COLS)
    ) u_colmap (
        .lo_byte (fb_rd_data[GW-1:0]),
        .hi_byte (fb_rd_data[NUM_COLS-1:GW]),
        .cols    (mapped)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:    state_nx = ST_DWELL;
            ST_DWELL:  if (expire) state_nx = plane_last ? ST_BLANK : ST_FETCH;
            ST_BLANK:  if (dly_q == DLY_W'(SETTLE_PRE - 1)) state_nx = ST_SHIFT;
            ST_SHIFT:  if (dly_q == DLY_W'(SHIFT_STEPS - 1)) state_nx = ST_SETTLE;
            ST_SETTLE: if (dly_q == DLY_W'(SETTLE_POST - 1)) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_DWELL;
            default:   state_nx = ST_OFF;
        endcase
        if (dis) state_nx = ST_OFF;
    end

    // state register and sequencing datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DWELL;
            plane_q <= LAST_PLANE;
            row_q   <= LAST_ROW;
            dly_q   <= '0;
            cmp_q   <= CMP_W'(START_DWELL);
            col_q   <= '0;
        end else begin
            state_q <= state_nx;
            dly_q   <= (state_nx != state_q) ? '0 : dly_q + DLY_W'(1);
            if (state_nx == ST_OFF) begin
                plane_q <= LAST_PLANE;
                row_q   <= LAST_ROW;
                cmp_q   <= CMP_W'(START_DWELL);
                col_q   <= '0;
            end else if (state_q == ST_DWELL && expire) begin
                if (plane_last) begin
                    plane_q <= '0;
                    row_q   <= (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
                    col_q   <= '0;
                end else begin
                    plane_q <= plane_q + PLANE_W'(1);
                end
            end else if (state_q == ST_LOAD) begin
                col_q <= mapped;
                cmp_q <= dwell_of(plane_q);
            end
        end
    end

    // outputs
    always_comb begin
        fb_rd_en   = (state_q == ST_FETCH);
        fb_rd_addr = {plane_q, buf_row};
        col_out    = col_q;
        row_clk    = 1'b0;
        row_dat    = INVERT_ROWS;
        unique case (state_q)
            ST_OFF:   row_dat = 1'b0;
            ST_SHIFT: begin
                row_clk = (dly_q == DLY_W'(1));
                if (row_q == '0 && dly_q != DLY_W'(SHIFT_STEPS - 1))
                    row_dat = ~INVERT_ROWS;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/led_scan_ctrl_chk.sv
module led_scan_ctrl_chk #(
    parameter int NUM_PLANES  = 3,
    parameter int NUM_COLS    = 16,
    parameter int PLANE_W     = 2,
    parameter bit INVERT_ROWS = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input led_scan_pkg::scan_state_e state_q,
    input logic [PLANE_W-1:0]        plane_q,
    input logic                      fb_rd_en,
    input logic                      row_clk,
    input logic                      row_dat,
    input logic [NUM_COLS-1:0]       col_out
);
    import led_scan_pkg::*;

    AST_PLANE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(plane_q) < NUM_PLANES);                                          // R3
    AST_COL_STABLE_DWELL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DWELL && $past(state_q) == ST_DWELL) |-> $stable(col_out)); // R2
    AST_BLANK_UNDER_CLK: assert property (@(posedge clk) disable iff (rst)
        row_clk |-> (col_out == '0));                                         // R4
    AST_CLK_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        row_clk |=> !row_clk);                                                // R5
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DWELL) |-> (row_dat == INVERT_ROWS));                  // R6
    AST_READ_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |=> !fb_rd_en);                                              // R7
    AST_COL_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (col_out != $past(col_out) && col_out != '0) |-> $past(fb_rd_en, 2)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF) |-> (col_out == '0 && !row_clk && !row_dat && !fb_rd_en)); // R12
endmodule

bind led_scan_ctrl led_scan_ctrl_chk #(
    .NUM_PLANES  (NUM_PLANES),
    .NUM_COLS    (NUM_COLS),
    .PLANE_W     (PLANE_W),
    .INVERT_ROWS (INVERT_ROWS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .plane_q  (plane_q),
    .fb_rd_en (fb_rd_en),
    .row_clk  (row_clk),
    .row_dat  (row_dat),
    .col_out  (col_out)
);

// File: tb/led_scan_ctrl_tb.sv
`timescale 1ns/1ps
module led_scan_ctrl_tb;
    localparam int P    = 2;
    localparam int SA   = 3;
    localparam int SB   = 5;
    localparam int FIRST = (20 + 1) * P + SA + 4 + SB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b0;
    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int ecount;

    logic       a_en, b_en, c_en;
    logic [5:0] a_addr, b_addr, c_addr;
    logic [15:0] a_rd, b_rd, c_rd;
    logic [15:0] a_col, b_col, c_col;
    logic       a_clk, b_clk, c_clk, a_dat, b_dat, c_dat;

    function automatic logic [15:0] fbd(input logic [5:0] a);
        logic [7:0] lo, hi;
        lo = 8'(int'(a) * 29 + 7);
        hi = 8'(int'(a) * 113) ^ 8'h5A;
        return {hi, lo};
    endfunction

    function automatic logic [15:0] cmap(input logic [15:0] d, input bit rev, input bit ilv);
        logic [15:0] c;
        c = '0;
        if (rev) begin
            for (int i = 0; i < 8; i++) begin
                c[i]     = d[15 - i];
                c[8 + i] = d[7 - i];
            end
        end else if (ilv) begin
            for (int i = 0; i < 4; i++) begin
                c[2*i]     = d[i];
                c[2*i + 1] = d[8 + i];
                c[8 + 2*i] = d[4 + i];
                c[9 + 2*i] = d[12 + i];
            end
        end else begin
            c = d;
        end
        return c;
    endfunction

    function automatic int ilrow(input int r);
        return (r % 2 == 1) ? (r / 2) + 8 : r / 2;
    endfunction

    led_scan_ctrl #(.PRESCALE(P), .SETTLE_PRE(SA), .SETTLE_POST(SB)) u_dut (
        .clk(clk), .rst(rst), .dis(dis), .fb_rd_en(a_en), .fb_rd_addr(a_addr),
        .fb_rd_data(a_rd), .col_out(a_col), .row_clk(a_clk), .row_dat(a_dat));
    led_scan_ctrl #(.PRESCALE(P), .SETTLE_PRE(SA), .SETTLE_POST(SB),
        .INVERT_ROWS(1'b1), .INTERLACE_ROWS(1'b1), .REVERSE_COLS(1'b1)) u_dut_b (
        .clk(clk), .rst(rst), .dis(dis), .fb_rd_en(b_en), .fb_rd_addr(b_addr),
        .fb_rd_data(b_rd), .col_out(b_col), .row_clk(b_clk), .row_dat(b_dat));
    led_scan_ctrl #(.PRESCALE(P), .SETTLE_PRE(SA), .SETTLE_POST(SB),
        .INTERLACE_COLS(1'b1)) u_dut_c (
        .clk(clk), .rst(rst), .dis(dis), .fb_rd_en(c_en), .fb_rd_addr(c_addr),
        .fb_rd_data(c_rd), .col_out(c_col), .row_clk(c_clk), .row_dat(c_dat));

    // frame-buffer models: one cycle read latency
    always_ff @(posedge clk) begin
        if (a_en) a_rd <= fbd(a_addr);
        if (b_en) b_rd <= fbd(b_addr);
        if (c_en) c_rd <= fbd(c_addr);
    end

    always_ff @(posedge clk) begin
        if (rst || dis) ecount <= 0;
        else            ecount <= ecount + 1;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, ecount);
        end
    endtask

    // monitor state
    bit          mon_on = 1'b0;
    int          next_fetch, col_due, clk_cnt, clk_at, exp_plane, exp_row;
    logic [15:0] prev_a, exp_a, exp_b, exp_c;
    bit          first_fetch;

    task automatic arm(input int first);
        next_fetch  = first;
        exp_plane   = 0;
        exp_row     = 0;
        clk_cnt     = 0;
        clk_at      = -100;
        col_due     = -100;
        first_fetch = 1'b1;
        mon_on      = 1'b1;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (a_en || ecount == next_fetch) begin
                int d;
                chk(first_fetch ? "R1 first dwell" : "R2 dwell length",
                    a_en ? ecount : -1, next_fetch);
                chk("R3 address", a_addr, exp_plane * 16 + exp_row);
                chk("R9 interlaced row address", b_addr, exp_plane * 16 + ilrow(exp_row));
                chk("R7 address", c_addr, exp_plane * 16 + exp_row);
                chk("R5 clock pulses", clk_cnt, (exp_plane == 0) ? 1 : 0);
                if (exp_plane == 0) chk("R4 clock position", clk_at, ecount - SB - 3);
                chk("R6 idle level", a_dat, 0);
                chk("R6 inverted idle level", b_dat, 1);
                prev_a  = a_col;
                exp_a   = cmap(fbd(6'(exp_plane * 16 + exp_row)), 1'b0, 1'b0);
                exp_b   = cmap(fbd(6'(exp_plane * 16 + ilrow(exp_row))), 1'b1, 1'b0);
                exp_c   = cmap(fbd(6'(exp_plane * 16 + exp_row)), 1'b0, 1'b1);
                col_due = ecount + 2;
                d = (exp_plane == 0) ? 3 : (exp_plane == 1) ? 4 : 22;
                next_fetch = ecount + 2 + (d + 1) * P + ((exp_plane == 2) ? SA + 4 + SB : 0);
                if (exp_plane == 2) begin
                    exp_plane = 0;
                    exp_row   = (exp_row + 1) % 16;
                end else begin
                    exp_plane = exp_plane + 1;
                end
                clk_cnt     = 0;
                first_fetch = 1'b0;
            end
            if (ecount == col_due - 1) chk("R7 columns held during load", a_col, prev_a);
            if (ecount == col_due) begin
                chk("R8 plain columns", a_col, exp_a);
                chk("R10 reversed columns", b_col, exp_b);
                chk("R11 interlaced columns", c_col, exp_c);
            end
            if (a_clk) begin
                clk_cnt++;
                clk_at = ecount;
                chk("R4 columns blank under clock", a_col, 0);
                chk("R5 token level", a_dat, (exp_row == 0) ? 1 : 0);
                chk("R6 inverted token level", b_dat, (exp_row == 0) ? 0 : 1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        arm(FIRST);
        @(negedge clk);
        // R1: reset state
        chk("R1 columns off", a_col, 0);
        chk("R1 no clock", a_clk, 0);
        chk("R1 no read", a_en, 0);
        chk("R1 idle data", a_dat, 0);
        chk("R1 inverted idle data", b_dat, 1);
        repeat (2800) @(negedge clk);
        // R12: disable in mid frame
        mon_on = 1'b0;
        dis = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R12 columns", a_col | b_col | c_col, 0);
            chk("R12 clock", {a_clk, b_clk, c_clk}, 0);
            chk("R12 data", {a_dat, b_dat, c_dat}, 0);
            chk("R12 read", {a_en, b_en, c_en}, 0);
        end
        dis = 1'b0;
        arm(FIRST + 1);
        repeat (1500) @(negedge clk);
        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule